// File: doc/BRIEF.md
# USB Device Endpoint Interrupt Aggregator

This block collects the interrupt events of a full-speed USB device controller that has one bidirectional control endpoint (endpoint 0, with separate IN and OUT status) and three data endpoints in each direction. Every endpoint raises a set of per-source event strobes. The block keeps these as sticky status bits that software clears by writing 1. One shared mask per direction decides which source kinds reach the global IN and OUT interrupt lines, and that mask applies to all endpoints of that direction, endpoint 0 included.

At every end of a periodic frame, the block raises a one-cycle end-of-frame interrupt. In that same cycle it reports, separately for each direction, whether any enabled isochronous data endpoint still has its transfer outstanding. The block also tracks the device's suspended state. Resume signalling that arrives while the device is suspended produces a resume interrupt and leaves suspend automatically. Packet handling, FIFOs and the transceiver are outside this block.

Top module: `ep_irq_hub`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, all status bits, both global endpoint interrupts, the frame-end, incomplete-isochronous and resume interrupts, and the suspended flag read 0.
- R2: An event strobe for source s of endpoint e (bit e*4+s of the event vector; endpoint 0 is e=0) sets the matching status bit. The bit is visible the cycle after the strobe and stays set until cleared.
- R3: A 1 on a clear-vector bit clears that status bit in the next cycle. If the event and the clear for the same bit arrive together, the bit ends up set.
- R4: The global interrupt of a direction is 1 exactly when some status bit of that direction is set and its source s is enabled by bit s of that direction's shared mask. The same mask bit applies to every endpoint, endpoint 0 included.
- R5: A frame-end strobe yields a frame-end interrupt in the following cycle, lasting exactly one cycle.
- R6: The incomplete-isochronous IN interrupt rises together with the frame-end interrupt when at least one enabled IN data endpoint whose type code is 01 (isochronous) has seen no transfer-complete event (source 0) since it was armed. A completion in the same cycle as the frame-end strobe counts as done.
- R7: The incomplete-isochronous OUT interrupt follows R6 with the OUT endpoints, OUT events and OUT types.
- R8: Endpoints typed 00 (control), 10 (bulk) or 11 (interrupt), disabled endpoints, and endpoint 0 never cause an incomplete-isochronous interrupt. Type field of data endpoint k (1..3) is bits 2(k-1)+1:2(k-1).
- R9: An endpoint is armed when its enable input rises and re-armed at every frame end while enabled. Dropping its enable discards the pending transfer.
- R10: A suspend strobe sets the suspended flag. A resume strobe while suspended clears the flag and gives a one-cycle resume interrupt in the next cycle. Resume wins over a simultaneous suspend strobe.
- R11: A resume strobe while not suspended changes nothing: no resume interrupt is produced and the suspended flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inEvt | input | 16 | IN event strobes, bit e*4+s |
| inClr | input | 16 | IN write-1-to-clear strobes |
| inMask | input | 4 | Shared IN per-source mask |
| inEpType | input | 6 | IN data endpoint type codes |
| inEpEn | input | 4 | IN endpoint enables, bit e |
| outEvt | input | 16 | OUT event strobes, bit e*4+s |
| outClr | input | 16 | OUT write-1-to-clear strobes |
| outMask | input | 4 | Shared OUT per-source mask |
| outEpType | input | 6 | OUT data endpoint type codes |
| outEpEn | input | 4 | OUT endpoint enables, bit e |
| frameEnd | input | 1 | End of periodic frame strobe |
| suspendReq | input | 1 | Suspend detected strobe |
| resumeStrobe | input | 1 | Resume signalling detected strobe |
| inStatus | output | 16 | IN sticky status bits |
| outStatus | output | 16 | OUT sticky status bits |
| inIrq | output | 1 | Global IN endpoint interrupt |
| outIrq | output | 1 | Global OUT endpoint interrupt |
| eopfIrq | output | 1 | End-of-frame interrupt pulse |
| isoInMiss | output | 1 | Incomplete isochronous IN pulse |
| isoOutMiss | output | 1 | Incomplete isochronous OUT pulse |
| resumeIrq | output | 1 | Resume interrupt pulse |
| suspended | output | 1 | Device suspended flag |

## Verification
Every single status bit of both directions is struck alone under all sixteen mask values. This separates a mask that is shared across endpoints from one that is indexed by endpoint or offset wrongly. The isochronous check sweeps all type codes of the three data endpoints against every enable pattern and every completion pattern, with the OUT side given a different completion pattern than the IN side. This exposes any leak from bulk, interrupt, control-coded or disabled endpoints, and any mix-up between the two directions. Directed sequences cover arming on a rising enable, dropping a pending transfer on disable, set-versus-clear collisions, and resume while suspended, while not suspended, and together with a suspend strobe.

// File: rtl/ep_irq_pkg.sv
package ep_irq_pkg;
  localparam int DATA_EPS  = 3;
  localparam int SRC_KINDS = 4;
  localparam int DONE_SRC  = 0;

  typedef enum logic [1:0] {
    EP_CTRL = 2'b00,
    EP_ISO  = 2'b01,
    EP_BULK = 2'b10,
    EP_INTR = 2'b11
  } epType_e;

  typedef struct packed {
    logic frameEdge;
    logic resumeHit;
  } ctrlStrb_t;
endpackage

// File: rtl/ep_irq_ctrl.sv
module ep_irq_ctrl
  import ep_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      frameEnd,
  input  logic      suspendReq,
  input  logic      resumeStrobe,
  output ctrlStrb_t strb,
  output logic      eopfIrq,
  output logic      resumeIrq,
  output logic      suspended
);
  always_comb begin
    strb.frameEdge = frameEnd;
    strb.resumeHit = resumeStrobe & suspended;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eopfIrq   <= 1'b0;
      resumeIrq <= 1'b0;
      suspended <= 1'b0;
    end else begin
      eopfIrq   <= strb.frameEdge;
      resumeIrq <= strb.resumeHit;
      if (strb.resumeHit)  suspended <= 1'b0;
      else if (suspendReq) suspended <= 1'b1;
    end
  end
endmodule

// File: rtl/ep_irq_dir.sv
module ep_irq_dir
  import ep_irq_pkg::*;
#(
  parameter int NUM_DATA_EP = DATA_EPS,
  parameter int NUM_SRC     = SRC_KINDS,
  localparam int NUM_EP     = NUM_DATA_EP + 1,
  localparam int STS_W      = NUM_EP * NUM_SRC
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrb_t                strb,
  input  logic [STS_W-1:0]         evt,
  input  logic [STS_W-1:0]         clr,
  input  logic [NUM_SRC-1:0]       mask,
  input  logic [2*NUM_DATA_EP-1:0] epType,
  input  logic [NUM_EP-1:0]        epEn,
  output logic [STS_W-1:0]         status,
  output logic                     irq,
  output logic                     isoMiss
);
  logic [STS_W-1:0]  maskRep;
  logic [NUM_EP-1:0] isoLate;
  logic [NUM_EP-1:0] enDly;

  always_ff @(posedge clk) begin
    if (!rstN) status <= '0;
    else       status <= (status & ~clr) | evt;
  end

  for (genvar e = 0; e < NUM_EP; e++) begin : g_mask
    assign maskRep[e*NUM_SRC +: NUM_SRC] = mask;
  end

  assign irq = |(status & maskRep);

  always_ff @(posedge clk) begin
    if (!rstN) enDly <= '0;
    else       enDly <= epEn;
  end

  assign isoLate[0] = 1'b0;

  for (genvar e = 1; e < NUM_EP; e++) begin : g_iso
    logic pend;
    logic done;
    logic isIso;
    assign done  = evt[e*NUM_SRC + DONE_SRC];
    assign isIso = (epType_e'(epType[2*(e-1) +: 2]) == EP_ISO);

    always_ff @(posedge clk) begin
      if (!rstN)                      pend <= 1'b0;
      else if (!epEn[e])              pend <= 1'b0;
      else if (strb.frameEdge)        pend <= 1'b1;
      else if (!enDly[e])             pend <= 1'b1;
      else if (done)                  pend <= 1'b0;
    end

    assign isoLate[e] = pend & ~done & epEn[e] & isIso;
  end

  always_ff @(posedge clk) begin
    if (!rstN) isoMiss <= 1'b0;
    else       isoMiss <= strb.frameEdge & (|isoLate);
  end
endmodule

// File: rtl/ep_irq_hub.sv
module ep_irq_hub
  import ep_irq_pkg::*;
#(
  parameter int NUM_DATA_EP = DATA_EPS,
  parameter int NUM_SRC     = SRC_KINDS,
  localparam int NUM_EP     = NUM_DATA_EP + 1,
  localparam int STS_W      = NUM_EP * NUM_SRC
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [STS_W-1:0]         inEvt,
  input  logic [STS_W-1:0]         inClr,
  input  logic [NUM_SRC-1:0]       inMask,
  input  logic [2*NUM_DATA_EP-1:0] inEpType,
  input  logic [NUM_EP-1:0]        inEpEn,
  input  logic [STS_W-1:0]         outEvt,
  input  logic [STS_W-1:0]         outClr,
  input  logic [NUM_SRC-1:0]       outMask,
  input  logic [2*NUM_DATA_EP-1:0] outEpType,
  input  logic [NUM_EP-1:0]        outEpEn,
  input  logic                     frameEnd,
  input  logic                     suspendReq,
  input  logic                     resumeStrobe,
  output logic [STS_W-1:0]         inStatus,
  output logic [STS_W-1:0]         outStatus,
  output logic                     inIrq,
  output logic                     outIrq,
  output logic                     eopfIrq,
  output logic                     isoInMiss,
  output logic                     isoOutMiss,
  output logic                     resumeIrq,
  output logic                     suspended
);
  ctrlStrb_t strb;

  ep_irq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .frameEnd(frameEnd), .suspendReq(suspendReq),
    .resumeStrobe(resumeStrobe), .strb(strb), .eopfIrq(eopfIrq),
    .resumeIrq(resumeIrq), .suspended(suspended)
  );

  ep_irq_dir #(.NUM_DATA_EP(NUM_DATA_EP), .NUM_SRC(NUM_SRC)) u_inDir (
    .clk(clk), .rstN(rstN), .strb(strb), .evt(inEvt), .clr(inClr),
    .mask(inMask), .epType(inEpType), .epEn(inEpEn), .status(inStatus),
    .irq(inIrq), .isoMiss(isoInMiss)
  );

  ep_irq_dir #(.NUM_DATA_EP(NUM_DATA_EP), .NUM_SRC(NUM_SRC)) u_outDir (
    .clk(clk), .rstN(rstN), .strb(strb), .evt(outEvt), .clr(outClr),
    .mask(outMask), .epType(outEpType), .epEn(outEpEn), .status(outStatus),
    .irq(outIrq), .isoMiss(isoOutMiss)
  );
endmodule

// File: rtl/ep_irq_hub_chk.sv
module ep_irq_hub_chk #(
  parameter int STS_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [STS_W-1:0] inEvt,
  input logic [STS_W-1:0] inClr,
  input logic [STS_W-1:0] outEvt,
  input logic [STS_W-1:0] inStatus,
  input logic [STS_W-1:0] outStatus,
  input logic             inIrq,
  input logic             frameEnd,
  input logic             resumeStrobe,
  input logic             eopfIrq,
  input logic             isoInMiss,
  input logic             isoOutMiss,
  input logic             resumeIrq,
  input logic             suspended
);
  // R2
  in_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inEvt != '0) |=> ((inStatus & $past(inEvt)) == $past(inEvt)));
  // R2
  out_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outEvt != '0) |=> ((outStatus & $past(outEvt)) == $past(outEvt)));
  // R3
  in_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inClr == '0) |=> ((($past(inStatus)) & ~inStatus) == '0));
  // R3
  in_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((inClr & ~inEvt) != '0) |=> ((inStatus & $past(inClr & ~inEvt)) == '0));
  // R4
  in_irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inStatus == '0) |-> !inIrq);
  // R5
  eopf_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |=> eopfIrq);
  // R5
  eopf_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameEnd |=> !eopfIrq);
  // R6
  iso_in_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    isoInMiss |-> eopfIrq);
  // R7
  iso_out_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    isoOutMiss |-> eopfIrq);
  // R10
  resume_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    resumeIrq |-> (!suspended && $past(suspended)));
  // R11
  resume_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!suspended && resumeStrobe) |=> (!resumeIrq && !suspended));
endmodule

bind ep_irq_hub ep_irq_hub_chk #(.STS_W(STS_W)) u_chk (
  .clk(clk), .rstN(rstN), .inEvt(inEvt), .inClr(inClr), .outEvt(outEvt),
  .inStatus(inStatus), .outStatus(outStatus), .inIrq(inIrq),
  .frameEnd(frameEnd), .resumeStrobe(resumeStrobe), .eopfIrq(eopfIrq),
  .isoInMiss(isoInMiss), .isoOutMiss(isoOutMiss), .resumeIrq(resumeIrq),
  .suspended(suspended)
);

// File: tb/ep_irq_hub_bench.sv
`timescale 1ns/1ps
module ep_irq_hub_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] inEvt = '0, inClr = '0, outEvt = '0, outClr = '0;
  logic [3:0]  inMask = '0, outMask = '0, inEpEn = '0, outEpEn = '0;
  logic [5:0]  inEpType = '0, outEpType = '0;
  logic frameEnd = 1'b0, suspendReq = 1'b0, resumeStrobe = 1'b0;
  logic [15:0] inStatus, outStatus;
  logic inIrq, outIrq, eopfIrq, isoInMiss, isoOutMiss, resumeIrq, suspended;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ep_irq_hub u_ep_irq_hub (
    .clk(clk), .rstN(rstN), .inEvt(inEvt), .inClr(inClr), .inMask(inMask),
    .inEpType(inEpType), .inEpEn(inEpEn), .outEvt(outEvt), .outClr(outClr),
    .outMask(outMask), .outEpType(outEpType), .outEpEn(outEpEn),
    .frameEnd(frameEnd), .suspendReq(suspendReq), .resumeStrobe(resumeStrobe),
    .inStatus(inStatus), .outStatus(outStatus), .inIrq(inIrq), .outIrq(outIrq),
    .eopfIrq(eopfIrq), .isoInMiss(isoInMiss), .isoOutMiss(isoOutMiss),
    .resumeIrq(resumeIrq), .suspended(suspended)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic clearAll();
    inClr = '1; outClr = '1;
    step();
    inClr = '0; outClr = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    // R1 during reset
    chk("R1", {inStatus, outStatus}, 32'h0);
    chk("R1", {inIrq, outIrq, eopfIrq, isoInMiss, isoOutMiss, resumeIrq, suspended}, 32'h0);
    rstN = 1'b1;
    step();
    // R1 first cycle after release
    chk("R1", {inStatus, outStatus}, 32'h0);
    chk("R1", {eopfIrq, resumeIrq, suspended}, 32'h0);

    // R2 / R4: each bit alone under every mask, both directions
    for (int dir = 0; dir < 2; dir++) begin
      for (int idx = 0; idx < 16; idx++) begin
        for (int m = 0; m < 16; m++) begin
          clearAll();
          inMask = 4'(m); outMask = 4'(m);
          if (dir == 0) inEvt = 16'(1 << idx); else outEvt = 16'(1 << idx);
          step();
          inEvt = '0; outEvt = '0;
          step();
          if (dir == 0) begin
            chk("R2", {inStatus, outStatus}, {16'(1 << idx), 16'h0});
            chk("R4", {inIrq, outIrq}, {m[idx % 4], 1'b0});
          end else begin
            chk("R2", {inStatus, outStatus}, {16'h0, 16'(1 << idx)});
            chk("R4", {inIrq, outIrq}, {1'b0, m[idx % 4]});
          end
        end
      end
    end

    // R3: clear and set/clear collision
    clearAll();
    inEvt = 16'hA5A5; step(); inEvt = '0; step();
    chk("R3", inStatus, 16'hA5A5);
    inClr = 16'h00FF; inEvt = 16'h0101; step(); inClr = '0; inEvt = '0; step();
    chk("R3", inStatus, 16'hA501);
    inClr = 16'h0100; step(); inClr = '0; step();
    chk("R3", inStatus, 16'hA401);
    clearAll(); step();
    chk("R3", inStatus, 16'h0);

    // R5: frame-end pulse length
    frameEnd = 1'b1; step(); frameEnd = 1'b0;
    chk("R5", eopfIrq, 1);
    step();
    chk("R5", eopfIrq, 0);

    // R6 / R7 / R8: sweep types, enables and completion patterns
    for (int t = 0; t < 64; t++) begin
      for (int en = 0; en < 8; en++) begin
        for (int d = 0; d < 8; d++) begin
          logic [2:0] dOut;
          logic expIn, expOut;
          dOut = 3'(d) ^ 3'b101;
          inEpEn = '0; outEpEn = '0;
          step();
          inEpType = 6'(t); outEpType = 6'(t);
          inEpEn = {3'(en), 1'b1}; outEpEn = {3'(en), 1'b1};
          frameEnd = 1'b1; step(); frameEnd = 1'b0;
          for (int k = 1; k < 4; k++) begin
            inEvt[k*4]  = d[k-1];
            outEvt[k*4] = dOut[k-1];
          end
          frameEnd = 1'b1;
          step();
          inEvt = '0; outEvt = '0; frameEnd = 1'b0;
          expIn = 1'b0; expOut = 1'b0;
          for (int k = 1; k < 4; k++) begin
            if (t[2*(k-1) +: 2] == 2'b01 && en[k-1]) begin
              if (!d[k-1])    expIn  = 1'b1;
              if (!dOut[k-1]) expOut = 1'b1;
            end
          end
          chk("R6", isoInMiss, expIn);
          chk("R7", isoOutMiss, expOut);
          chk("R8", eopfIrq, 1);
        end
      end
    end
    clearAll();

    // R9: arming on rising enable, rearm at frame end, drop on disable
    inEpType = 6'b010101; inEpEn = '0; step(); step();
    inEpEn = 4'b0010; step(); step();
    frameEnd = 1'b1; step(); frameEnd = 1'b0;
    chk("R9", isoInMiss, 1);
    inEvt = 16'h0010; step(); inEvt = '0; step();
    frameEnd = 1'b1; step(); frameEnd = 1'b0;
    chk("R9", isoInMiss, 0);
    step();
    frameEnd = 1'b1; step(); frameEnd = 1'b0;
    chk("R9", isoInMiss, 1);
    inEpEn = 4'b0000; step(); step();
    frameEnd = 1'b1; step(); frameEnd = 1'b0;
    chk("R9", isoInMiss, 0);
    // R8: endpoint 0 enabled but never counts
    inEpEn = 4'b0001; step();
    frameEnd = 1'b1; step(); frameEnd = 1'b0;
    chk("R8", isoInMiss, 0);
    inEpEn = '0;

    // R11: resume while awake
    resumeStrobe = 1'b1; step(); resumeStrobe = 1'b0;
    chk("R11", {resumeIrq, suspended}, 0);
    // R10: suspend then resume
    suspendReq = 1'b1; step(); suspendReq = 1'b0;
    chk("R10", {resumeIrq, suspended}, 2'b01);
    step();
    chk("R10", suspended, 1);
    resumeStrobe = 1'b1; step(); resumeStrobe = 1'b0;
    chk("R10", {resumeIrq, suspended}, 2'b10);
    step();
    chk("R10", {resumeIrq, suspended}, 2'b00);
    // R10: resume wins over simultaneous suspend
    suspendReq = 1'b1; step();
    resumeStrobe = 1'b1; step(); suspendReq = 1'b0; resumeStrobe = 1'b0;
    chk("R10", {resumeIrq, suspended}, 2'b10);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule